// File: doc/BRIEF.md
# Initiator-Aware Address Decoder with Local Error Response

This block sits at the front of a small interconnect. Each request carries a 40-bit address and a 2-bit initiator code. The block works out which downstream port should take the request. There are nine ports: a host-link outbound port, five 64 KB peripheral windows, an on-chip RAM, a spare bus-slave window and an external memory window. A region is only usable by the initiators that are allowed to reach it. When the decode is good, the request handshake passes straight through to the selected port, with no added cycles.

The block answers some requests itself instead of forwarding them. A request to a reserved region, a request to a region its initiator may not use, or a request with an invalid initiator code gets a locally generated decode-error response. The spare windows behave differently. An access to a spare window that has nothing attached, or whose initiator is not allowed there, is absorbed and completed with an OKAY response. Write data is dropped and read data comes back as zero. The local response is registered and is held until the response side accepts it.

The request address bus is shared by all ports; only the valid and ready signals are steered.

Top module: `initiator_addr_decoder`

## Requirements
- R1: Addresses 0x00_0000_0000..0x00_2EFF_FFFF and 0x00_3000_0000..0x00_5FFF_FFFF go to port 0 (host-link outbound) for initiator codes 2'b01 (DMA) and 2'b10 (expansion). Initiator 2'b00 (host link) gets a decode error there.
- R2: Addresses 0x00_2F00_0000..0x00_2FFF_FFFF return a decode error for every initiator.
- R3: The five 64 KB windows based at 0x6001_0000, 0x6002_0000, 0x6003_0000, 0x6004_0000 and 0x6005_0000 select ports 1 to 5, in ascending address order. Initiators 2'b00 and 2'b10 may reach them. Initiator 2'b01 gets a decode error on ports 1 to 3.
- R4: Every initiator may reach three regions: 0x6010_0000..0x6011_FFFF goes to port 6 (RAM), 0x6400_0000..0x67FF_FFFF goes to port 7 (spare slave), and 0x6800_0000..0x6FFF_FFFF goes to port 8 (external memory).
- R5: Addresses 0x00_7000_0000 up to the top of the address space go to port 0 for initiator 2'b10 only. Every other initiator gets a decode error.
- R6: The gaps 0x6000_0000..0x6000_FFFF, 0x6006_0000..0x600F_FFFF, 0x6012_0000..0x601F_FFFF and 0x6020_0000..0x63FF_FFFF return a decode error.
- R7: Initiator code 2'b11 returns a decode error for every address and never raises a port valid.
- R8: Ports 4, 5 and 7 are spare. Parameter SPARE_ATTACH bit 0, bit 1 and bit 2 mark ports 4, 5 and 7 as attached. A spare-port access is absorbed with response code 2'b00 (OKAY), zero read data and no port valid in two cases: the port is unattached, or the initiator is not allowed there.
- R9: A local response (OKAY 2'b00 or decode error 2'b11) sets resp_valid in the cycle after the request handshake. resp_valid and the response code stay unchanged until resp_ready is seen high.
- R10: While a local response is pending, req_ready is low and no port valid is raised.
- R11: A forwarded request raises exactly one tgt_valid bit, the one for the selected port. req_ready follows that port's tgt_ready, and no local response is produced.
- R12: During and right after reset, resp_valid is low and all tgt_valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (routed or local) |
| req_addr | input | ADDR_W (40) | Request address |
| req_master | input | 2 | Initiator code: 00 host link, 01 DMA, 10 expansion, 11 invalid |
| tgt_valid | output | N_TGT (9) | One-hot request valid per downstream port |
| tgt_ready | input | N_TGT (9) | Ready from each downstream port |
| resp_valid | output | 1 | Local response valid |
| resp_ready | input | 1 | Local response accepted |
| resp_code | output | 2 | Local response code: 00 OKAY, 11 decode error |
| resp_rdata | output | DATA_W (32) | Read data of local responses (always zero) |

## Verification
The bench probes the edges of each range: the last byte before the reserved 16 MB hole, the first and last bytes of each window, and the very top of the 40-bit space. An off-by-one comparator would either send a reserved address to a port or turn a legal access into an error. It checks every region against every initiator, so a permission mask that is shifted or inverted shows up as a wrong port or a wrong error. It treats spare windows separately: unattached, attached, and not permitted. A design that returned an error there, or raised a port valid, would be caught. Finally, it holds resp_ready low while a new routable request waits. This exposes a design that overwrites or drops the pending response, or that leaks a port valid while stalled.

// File: rtl/dec_pkg.sv
package dec_pkg;

   localparam int N_TGT = 9;
   localparam int N_REG = 11;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_DECERR = 2'b11
   } resp_e;

   typedef enum logic [1:0] {
      K_FWD    = 2'd0,
      K_ABSORB = 2'd1,
      K_ERR    = 2'd2
   } dec_kind_e;

   // lower bound of region k
   function automatic logic [63:0] reg_lo(input int k);
      case (k)
         0:       return 64'h0000_0000;
         1:       return 64'h3000_0000;
         2, 3, 4, 5, 6:
                  return 64'h6001_0000 + 64'(k - 2) * 64'h1_0000;
         7:       return 64'h6010_0000;
         8:       return 64'h6400_0000;
         9:       return 64'h6800_0000;
         default: return 64'h7000_0000;
      endcase
   endfunction

   // upper bound (inclusive) of region k, top region reaches the end of space
   function automatic logic [63:0] reg_hi(input int k, input int aw);
      case (k)
         0:       return 64'h2EFF_FFFF;
         1:       return 64'h5FFF_FFFF;
         2, 3, 4, 5, 6:
                  return reg_lo(k) + 64'hFFFF;
         7:       return 64'h6011_FFFF;
         8:       return 64'h67FF_FFFF;
         9:       return 64'h6FFF_FFFF;
         default: return (64'd1 << aw) - 64'd1;
      endcase
   endfunction

   // downstream port of region k
   function automatic int reg_tgt(input int k);
      case (k)
         0, 1:          return 0;
         2, 3, 4, 5, 6: return k - 1;
         7:             return 6;
         8:             return 7;
         9:             return 8;
         default:       return 0;
      endcase
   endfunction

   // permission mask, bit m set when initiator code m may use region k
   function automatic logic [3:0] reg_allow(input int k);
      case (k)
         0, 1:          return 4'b0110;
         2, 3, 4, 5, 6: return 4'b0101;
         7, 8, 9:       return 4'b0111;
         default:       return 4'b0100;
      endcase
   endfunction

   function automatic bit is_spare(input int t);
      return (t == 4) || (t == 5) || (t == 7);
   endfunction

   // which SPARE_ATTACH bit belongs to spare port t
   function automatic int spare_bit(input int t);
      case (t)
         4:       return 0;
         5:       return 1;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/dec_region_match.sv
module dec_region_match #(
   parameter int ADDR_W  = 40,
   parameter int REG_IDX = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   import dec_pkg::*;

   localparam logic [63:0] LO = reg_lo(REG_IDX);
   localparam logic [63:0] HI = reg_hi(REG_IDX, ADDR_W);

   logic [63:0] a64;
   assign a64 = {{(64-ADDR_W){1'b0}}, addr};

   generate
      if (LO == 64'd0) begin : g_floor
         assign hit = (a64 <= HI);
      end else begin : g_window
         assign hit = (a64 >= LO) && (a64 <= HI);
      end
   endgenerate

endmodule

// File: rtl/dec_route.sv
module dec_route #(
   parameter int         N_REG        = 11,
   parameter int         N_TGT        = 9,
   parameter logic [2:0] SPARE_ATTACH = 3'b000
) (
   input  logic [N_REG-1:0] hit,
   input  logic [1:0]       master,
   output dec_pkg::dec_kind_e kind,
   output logic [N_TGT-1:0] sel_oh
);
   import dec_pkg::*;

   always_comb begin : p_route
      int         t;
      logic [3:0] allow;
      logic       perm;
      kind   = K_ERR;
      sel_oh = '0;
      t      = 0;
      allow  = '0;
      perm   = 1'b0;
      for (int r = 0; r < N_REG; r++) begin
         if (hit[r]) begin
            t     = reg_tgt(r);
            allow = reg_allow(r);
            perm  = allow[master];
            if (master == 2'b11) begin
               kind = K_ERR;
            end else if (is_spare(t) && (!perm || !SPARE_ATTACH[spare_bit(t)])) begin
               kind = K_ABSORB;
            end else if (perm) begin
               kind      = K_FWD;
               sel_oh[t] = 1'b1;
            end else begin
               kind = K_ERR;
            end
         end
      end
   end

endmodule

// File: rtl/dec_local_resp.sv
module dec_local_resp (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  dec_pkg::resp_e code_i,
   input  logic          resp_ready_i,
   output logic          resp_valid_o,
   output dec_pkg::resp_e resp_code_o
);
   import dec_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid_o <= 1'b0;
         resp_code_o  <= RESP_OKAY;
      end else if (load_i) begin
         resp_valid_o <= 1'b1;
         resp_code_o  <= code_i;
      end else if (resp_valid_o && resp_ready_i) begin
         resp_valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/initiator_addr_decoder.sv
module initiator_addr_decoder #(
   parameter int         ADDR_W       = 40,
   parameter int         DATA_W       = 32,
   parameter logic [2:0] SPARE_ATTACH = 3'b000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [1:0]                 req_master,
   output logic [dec_pkg::N_TGT-1:0]  tgt_valid,
   input  logic [dec_pkg::N_TGT-1:0]  tgt_ready,
   output logic                       resp_valid,
   input  logic                       resp_ready,
   output logic [1:0]                 resp_code,
   output logic [DATA_W-1:0]          resp_rdata
);
   import dec_pkg::*;

   localparam int NT = N_TGT;
   localparam int NR = N_REG;

   generate
      if (ADDR_W < 31 || ADDR_W > 63) begin : g_bad_addr_w
         $error("ADDR_W must be between 31 and 63");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be at least 8");
      end
   endgenerate

   logic [NR-1:0] hit;
   logic [NT-1:0] sel_oh;
   dec_kind_e     kind;
   logic          pending;
   logic          load;
   resp_e         load_code;
   resp_e         held_code;

   generate
      for (genvar r = 0; r < NR; r++) begin : g_region
         dec_region_match #(
            .ADDR_W  (ADDR_W),
            .REG_IDX (r)
         ) u_match (
            .addr (req_addr),
            .hit  (hit[r])
         );
      end
   endgenerate

   dec_route #(
      .N_REG        (NR),
      .N_TGT        (NT),
      .SPARE_ATTACH (SPARE_ATTACH)
   ) u_route (
      .hit    (hit),
      .master (req_master),
      .kind   (kind),
      .sel_oh (sel_oh)
   );

   assign pending   = resp_valid;
   assign tgt_valid = (req_valid && !pending) ? sel_oh : '0;
   assign req_ready = !pending && ((kind == K_FWD) ? |(sel_oh & tgt_ready) : 1'b1);
   assign load      = req_valid && req_ready && (kind != K_FWD);
   assign load_code = (kind == K_ERR) ? RESP_DECERR : RESP_OKAY;

   dec_local_resp u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load),
      .code_i       (load_code),
      .resp_ready_i (resp_ready),
      .resp_valid_o (resp_valid),
      .resp_code_o  (held_code)
   );

   assign resp_code  = held_code;
   assign resp_rdata = '0;

endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
   parameter int N_TGT  = 9,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_master,
   input logic [N_TGT-1:0]  tgt_valid,
   input logic [N_TGT-1:0]  tgt_ready,
   input logic              resp_valid,
   input logic              resp_ready,
   input logic [1:0]        resp_code,
   input logic [DATA_W-1:0] resp_rdata
);

   a_r11_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_valid));

   a_r11_ready_tracks_port: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid != '0) |-> (req_ready == |(tgt_valid & tgt_ready)));

   a_r10_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (!req_ready && tgt_valid == '0));

   a_r9_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_code)));

   a_r9_resp_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resp_valid) |-> $past(req_valid && req_ready && tgt_valid == '0));

   a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (resp_code == 2'b00 || resp_code == 2'b11));

   a_r7_bad_master: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_master == 2'b11) |-> (tgt_valid == '0));

   a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == 2'b00) |-> (resp_rdata == '0));

endmodule

bind initiator_addr_decoder dec_checker #(
   .N_TGT  (dec_pkg::N_TGT),
   .DATA_W (DATA_W)
) u_dec_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_master (req_master),
   .tgt_valid  (tgt_valid),
   .tgt_ready  (tgt_ready),
   .resp_valid (resp_valid),
   .resp_ready (resp_ready),
   .resp_code  (resp_code),
   .resp_rdata (resp_rdata)
);

// File: tb/test_initiator_addr_decoder.sv
`timescale 1ns/100ps
module test_initiator_addr_decoder;

   localparam logic [2:0] ATTACH = 3'b100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic [1:0]  req_master = 2'b00;
   logic [8:0]  tgt_valid;
   logic [8:0]  tgt_ready = '1;
   logic        resp_valid;
   logic        resp_ready = 1'b0;
   logic [1:0]  resp_code;
   logic [31:0] resp_rdata;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   initiator_addr_decoder #(
      .ADDR_W       (40),
      .DATA_W       (32),
      .SPARE_ATTACH (ATTACH)
   ) i_initiator_addr_decoder (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_master (req_master),
      .tgt_valid  (tgt_valid),
      .tgt_ready  (tgt_ready),
      .resp_valid (resp_valid),
      .resp_ready (resp_ready),
      .resp_code  (resp_code),
      .resp_rdata (resp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // kind: 0 forward, 1 absorbed OKAY, 2 decode error
   function automatic void model(input logic [39:0] a, input logic [1:0] m,
                                 output int kind, output int idx);
      bit host, dma;
      kind = 2;
      idx  = 0;
      host = (m == 2'b00);
      dma  = (m == 2'b01);
      if (m == 2'b11) return;
      if (a <= 40'h2E_FFFF_FF || (a >= 40'h30_0000_00 && a <= 40'h5F_FFFF_FF)) begin
         if (!host) kind = 0;
      end else if (a >= 40'h60_0100_00 && a <= 40'h60_05FF_FF) begin
         int p;
         p   = int'((a - 40'h60_0100_00) >> 16);
         idx = 1 + p;
         if (p >= 3) kind = (!dma && ATTACH[p-3]) ? 0 : 1;
         else if (!dma) kind = 0;
      end else if (a >= 40'h60_1000_00 && a <= 40'h60_11FF_FF) begin
         kind = 0; idx = 6;
      end else if (a >= 40'h64_0000_00 && a <= 40'h67_FFFF_FF) begin
         idx  = 7;
         kind = ATTACH[2] ? 0 : 1;
      end else if (a >= 40'h68_0000_00 && a <= 40'h6F_FFFF_FF) begin
         kind = 0; idx = 8;
      end else if (a >= 40'h70_0000_00) begin
         if (m == 2'b10) kind = 0;
      end
   endfunction

   task automatic do_req(input logic [39:0] a, input logic [1:0] m, input int hold, input string tag);
      int kind, idx;
      model(a, m, kind, idx);
      @(negedge clk);
      req_valid  = 1'b1;
      req_addr   = a;
      req_master = m;
      #1;
      if (kind == 0) chk(tgt_valid == 9'(1 << idx), tag, longint'(tgt_valid), longint'(1 << idx));
      else           chk(tgt_valid == '0, tag, longint'(tgt_valid), 0);
      chk(req_ready == 1'b1, tag, longint'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      if (kind == 0) begin
         chk(resp_valid == 1'b0, {tag, " no local resp (R11)"}, longint'(resp_valid), 0);
      end else begin
         chk(resp_valid == 1'b1, {tag, " resp next cycle (R9)"}, longint'(resp_valid), 1);
         chk(resp_code == ((kind == 2) ? 2'b11 : 2'b00), tag, longint'(resp_code),
             (kind == 2) ? 3 : 0);
         chk(resp_rdata == '0, {tag, " zero data (R8)"}, longint'(resp_rdata), 0);
         for (int h = 0; h < hold; h++) begin
            req_valid  = 1'b1;
            req_addr   = 40'h60_1000_00;
            req_master = 2'b00;
            #1;
            chk(req_ready == 1'b0 && tgt_valid == '0, "R10 stall",
                longint'({req_ready, tgt_valid}), 0);
            @(negedge clk);
            #1;
            chk(resp_valid == 1'b1 && resp_code == ((kind == 2) ? 2'b11 : 2'b00),
                "R9 hold", longint'({resp_valid, resp_code}),
                (kind == 2) ? 7 : 4);
         end
         req_valid  = 1'b0;
         resp_ready = 1'b1;
         @(negedge clk);
         resp_ready = 1'b0;
         #1;
         chk(resp_valid == 1'b0, "R9 release", longint'(resp_valid), 0);
      end
   endtask

   // every-cycle comparison of the port-side invariants
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk($onehot0(tgt_valid), "R11 onehot", longint'(tgt_valid), 0);
         if (resp_valid) chk(req_ready == 1'b0, "R10 ready", longint'(req_ready), 0);
      end
   end

   task automatic report;
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(resp_valid == 1'b0 && tgt_valid == '0, "R12 in reset",
          longint'({resp_valid, tgt_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(resp_valid == 1'b0 && tgt_valid == '0, "R12 after reset",
          longint'({resp_valid, tgt_valid}), 0);

      do_req(40'h00_0000_1000, 2'b01, 0, "R1 dma low");
      do_req(40'h00_2EFF_FFFF, 2'b01, 0, "R1 edge below hole");
      do_req(40'h00_5FFF_FFFC, 2'b10, 0, "R1 expansion upper");
      do_req(40'h00_0000_1000, 2'b00, 1, "R1 host refused");
      do_req(40'h00_2F00_0000, 2'b10, 0, "R2 hole start");
      do_req(40'h00_2FFF_FFFF, 2'b01, 2, "R2 hole end");
      do_req(40'h00_6001_0000, 2'b00, 0, "R3 port1");
      do_req(40'h00_6002_0004, 2'b00, 0, "R3 port2");
      do_req(40'h00_6003_FFFC, 2'b10, 0, "R3 port3");
      do_req(40'h00_6001_0000, 2'b01, 0, "R3 dma refused");
      do_req(40'h00_6010_0000, 2'b01, 0, "R4 ram dma");
      do_req(40'h00_6011_FFFF, 2'b00, 0, "R4 ram top");
      do_req(40'h00_6400_0000, 2'b00, 0, "R4 spare slave attached");
      do_req(40'h00_6800_0000, 2'b01, 0, "R4 ext mem");
      do_req(40'h00_6FFF_FFFF, 2'b10, 0, "R4 ext mem top");
      do_req(40'h00_7000_0000, 2'b10, 0, "R5 upper start");
      do_req(40'hFF_FFFF_FFFF, 2'b10, 0, "R5 top of space");
      do_req(40'h00_7000_0000, 2'b00, 0, "R5 host refused");
      do_req(40'h12_0000_0000, 2'b01, 0, "R5 dma refused");
      do_req(40'h00_6000_0000, 2'b00, 0, "R6 gap0");
      do_req(40'h00_6006_0000, 2'b10, 0, "R6 gap1");
      do_req(40'h00_6012_0000, 2'b01, 0, "R6 gap2");
      do_req(40'h00_63FF_FFFC, 2'b00, 1, "R6 gap3");
      do_req(40'h00_6010_0000, 2'b11, 0, "R7 bad initiator ram");
      do_req(40'h00_6004_0000, 2'b11, 0, "R7 bad initiator spare");
      do_req(40'h00_6004_0000, 2'b00, 2, "R8 spare port4 unattached");
      do_req(40'h00_6005_FFFC, 2'b10, 0, "R8 spare port5 unattached");
      do_req(40'h00_6005_0000, 2'b01, 0, "R8 spare dma absorbed");

      // R11: forwarded request waits on its port's ready
      @(negedge clk);
      tgt_ready  = 9'h1FF & ~9'(1 << 6);
      req_valid  = 1'b1;
      req_addr   = 40'h00_6010_0040;
      req_master = 2'b10;
      #1;
      chk(tgt_valid == 9'(1 << 6) && req_ready == 1'b0, "R11 wait",
          longint'({req_ready, tgt_valid}), longint'(1 << 6));
      @(negedge clk);
      #1;
      chk(tgt_valid == 9'(1 << 6) && req_ready == 1'b0 && resp_valid == 1'b0, "R11 still waiting",
          longint'({resp_valid, req_ready, tgt_valid}), longint'(1 << 6));
      tgt_ready = '1;
      #1;
      chk(req_ready == 1'b1, "R11 ready follows port", longint'(req_ready), 1);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(resp_valid == 1'b0 && tgt_valid == '0, "R11 done",
          longint'({resp_valid, tgt_valid}), 0);

      repeat (2) @(negedge clk);
      report();
      $finish;
   end

endmodule